// File: doc/BRIEF.md
# Memory Module Bank Configuration Unit

This block is the byte-wide register front end of a memory controller that serves six memory-module sockets. At reset it turns a static "requested memory in MB" input into a per-socket module size, filling sockets two at a time. Software then reads back which sockets are populated and which of them hold large (32 MB) modules. It also reads a fixed parity status byte.

Bank boundaries are set through one shared size register. A write carries a slot number and an end boundary in 8 MB units. A bank's start is the end boundary stored for the slot below it, so the banks chain. Reads of the size register walk the stored boundaries through an automatic index. Reading the presence register rewinds that index to 0. When auto-configuration is on, reset places every populated socket back to back from address 0.

A decode port takes the 8 MB page number of a physical address. It returns a one-hot select for the socket that owns the page, or a miss flag.

Top module: `simm_bank_cfg`

## Requirements
- R1: A read at I/O address 0x803 returns bit n (n = 0..5) set exactly when socket n holds a 32 MB module; bits 7:6 read 0.
- R2: A read at 0x804 returns bit n cleared exactly when socket n is populated (active-low presence); bits 7:6 always read 1.
- R3: Socket sizes come from the requested size in MB, taken over socket pairs 0-1, 2-3, 4-5 in that order. A remainder of at least 64 gives the pair two 32 MB modules and takes 64 away. Otherwise a remainder of at least 16 gives two 8 MB modules and takes 16 away. Otherwise the pair is empty, and any leftover is dropped.
- R4: A read at 0x820 returns, in bits 4:0, the end value stored at the current index, with bits 7:5 at 0. On the edge that ends the read, the index advances modulo 8.
- R5: Any read at 0x804 sets the size index to 0 on the edge that ends the access.
- R6: A write at 0x820 stores data bits 4:0 as the end value of the slot named by data bits 7:5. This holds for all eight slots, including 0 and 7.
- R7: A write to slot k (k = 1..6) with socket k-1 populated sets that socket's start. The start is 0 when k is 1, and otherwise the end value stored in slot k-1. The socket's base becomes start × 8 MB, and the socket is enabled only if the new end differs from the start. Writes to slots 0 and 7 change no socket.
- R8: A read at 0x841 always returns 0x01 (no parity error).
- R9: Reads of any other I/O address return 0x00, and writes to them change nothing.
- R10: Reset sets the index and all eight end values to 0. With auto-configure on, every populated socket is enabled, and bases are assigned contiguously from 0 in socket order. With it off, all sockets are disabled.
- R11: The decoder selects, one-hot, the lowest-numbered enabled socket whose range [base, base + module size) contains the page. When no socket matches it raises the miss output and selects nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req_mb | input | 8 | Static requested memory size in MB |
| cfg_auto | input | 1 | Static auto-configure enable, applied at reset |
| io_addr | input | 12 | I/O register address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational on the read strobe |
| dec_page | input | 5 | Physical address bits 27:23 (8 MB page) |
| dec_sel | output | 6 | One-hot socket select |
| dec_miss | output | 1 | No socket owns the page |

## Verification
The bench targets the index edge cases: wrapping from slot 7 back to slot 0, a rewind that falls mid-walk, and writes to slots 0 and 7. A design that mishandled these would return boundaries from the wrong slot, or move a socket on a write that should touch none. It checks the chaining by writing a boundary equal to the previous slot's end. A design that tested the end against zero instead of against the start would leave that bank enabled. It builds overlapping banks to show that decode picks the lowest socket, and it covers requests such as 40, 130 and 200 MB. An allocator that skipped the 8 MB fallback or kept a leftover would report the wrong presence and ID bits.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
    localparam int N_SOCK      = 6;
    localparam int SLOT_W      = 3;
    localparam int N_SLOT      = 1 << SLOT_W;
    localparam int END_W       = 5;
    localparam int DATA_W      = 8;
    localparam int IO_AW       = 12;
    localparam int REQ_W       = 8;
    localparam int PAGE_SH     = 23;
    localparam int PA_W        = END_W + PAGE_SH;
    localparam int BIG_PAIR_MB = 64;
    localparam int SML_PAIR_MB = 16;

    localparam logic [IO_AW-1:0] A_BIGID  = 12'h803;
    localparam logic [IO_AW-1:0] A_PRES   = 12'h804;
    localparam logic [IO_AW-1:0] A_SIZE   = 12'h820;
    localparam logic [IO_AW-1:0] A_PARITY = 12'h841;
    localparam logic [DATA_W-1:0] PARITY_OK = 8'h01;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_8M   = 2'd1,
        SZ_32M  = 2'd2
    } sock_size_e;

    typedef struct packed {
        logic             en;
        logic [END_W-1:0] base;
    } bank_t;

    function automatic logic [END_W-1:0] size_pages(sock_size_e s);
        case (s)
            SZ_32M:  return END_W'(4);
            SZ_8M:   return END_W'(1);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/mcfg_alloc.sv
module mcfg_alloc
    import mcfg_pkg::*;
#(
    parameter int NS = N_SOCK
) (
    input  logic [REQ_W-1:0]        req_mb,
    output sock_size_e [NS-1:0]     sizes
);
    localparam int NPAIR = NS / 2;

    logic [REQ_W-1:0] rem [NPAIR+1];
    assign rem[0] = req_mb;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic big, sml;
        assign big = rem[p] >= REQ_W'(BIG_PAIR_MB);
        assign sml = !big && (rem[p] >= REQ_W'(SML_PAIR_MB));
        assign sizes[2*p]   = big ? SZ_32M : (sml ? SZ_8M : SZ_NONE);
        assign sizes[2*p+1] = big ? SZ_32M : (sml ? SZ_8M : SZ_NONE);
        assign rem[p+1] = rem[p] - (big ? REQ_W'(BIG_PAIR_MB)
                                        : (sml ? REQ_W'(SML_PAIR_MB) : '0));
    end
endmodule

// File: rtl/mcfg_regs.sv
module mcfg_regs
    import mcfg_pkg::*;
#(
    parameter int NS = N_SOCK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                auto_cfg,
    input  sock_size_e [NS-1:0] sizes,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    output bank_t [NS-1:0]      banks
);
    logic [SLOT_W-1:0] idx;
    logic [END_W-1:0]  end_tbl [N_SLOT];
    logic [NS-1:0]     populated, big;
    bank_t [NS-1:0]    auto_banks;

    logic              rd_size, rd_pres, wr_size;
    logic [SLOT_W-1:0] w_slot;
    logic [END_W-1:0]  w_end;

    assign rd_size = io_rd && (io_addr == A_SIZE);
    assign rd_pres = io_rd && (io_addr == A_PRES);
    assign wr_size = io_wr && (io_addr == A_SIZE);
    assign w_slot  = io_wdata[DATA_W-1 -: SLOT_W];
    assign w_end   = io_wdata[END_W-1:0];

    for (genvar s = 0; s < NS; s++) begin : g_pop
        assign populated[s] = sizes[s] != SZ_NONE;
        assign big[s]       = sizes[s] == SZ_32M;
    end

    // contiguous placement used when auto-configure is on
    always_comb begin
        logic [END_W-1:0] acc;
        acc = '0;
        for (int s = 0; s < NS; s++) begin
            auto_banks[s].en   = populated[s];
            auto_banks[s].base = acc;
            acc = acc + size_pages(sizes[s]);
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (io_addr)
                A_BIGID:  io_rdata = DATA_W'(big);
                A_PRES: begin
                    io_rdata = '1;
                    io_rdata[NS-1:0] = ~populated;
                end
                A_SIZE:   io_rdata = DATA_W'(end_tbl[idx]);
                A_PARITY: io_rdata = PARITY_OK;
                default:  io_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            for (int i = 0; i < N_SLOT; i++) end_tbl[i] <= '0;
            banks <= auto_cfg ? auto_banks : '0;
        end else begin
            if (rd_pres)      idx <= '0;
            else if (rd_size) idx <= idx + 1'b1;
            if (wr_size) begin
                end_tbl[w_slot] <= w_end;
                for (int s = 0; s < NS; s++) begin
                    if (w_slot == SLOT_W'(s + 1) && populated[s]) begin
                        logic [END_W-1:0] start;
                        start = (s == 0) ? '0 : end_tbl[s];
                        banks[s].en   <= w_end != start;
                        banks[s].base <= start;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mcfg_decode.sv
module mcfg_decode
    import mcfg_pkg::*;
#(
    parameter int NS = N_SOCK
) (
    input  sock_size_e [NS-1:0] sizes,
    input  bank_t [NS-1:0]      banks,
    input  logic [END_W-1:0]    page,
    output logic [NS-1:0]       sel,
    output logic                miss
);
    logic [NS-1:0] hit;

    for (genvar s = 0; s < NS; s++) begin : g_cmp
        logic [END_W:0] lo, hi, pg;
        assign lo = {1'b0, banks[s].base};
        assign hi = lo + {1'b0, size_pages(sizes[s])};
        assign pg = {1'b0, page};
        assign hit[s] = banks[s].en && (pg >= lo) && (pg < hi);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int s = 0; s < NS; s++) begin
            if (hit[s] && !found) begin
                sel[s] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign miss = ~|hit;
endmodule

// File: rtl/simm_bank_cfg.sv
module simm_bank_cfg
    import mcfg_pkg::*;
#(
    parameter int NS = N_SOCK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REQ_W-1:0]  cfg_req_mb,
    input  logic              cfg_auto,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [END_W-1:0]  dec_page,
    output logic [NS-1:0]     dec_sel,
    output logic              dec_miss
);
    sock_size_e [NS-1:0] sizes;
    bank_t [NS-1:0]      banks;

    mcfg_alloc #(.NS(NS)) u_alloc (
        .req_mb (cfg_req_mb),
        .sizes  (sizes)
    );

    mcfg_regs #(.NS(NS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .auto_cfg (cfg_auto),
        .sizes    (sizes),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .banks    (banks)
    );

    mcfg_decode #(.NS(NS)) u_dec (
        .sizes (sizes),
        .banks (banks),
        .page  (dec_page),
        .sel   (dec_sel),
        .miss  (dec_miss)
    );
endmodule

// File: rtl/simm_bank_cfg_chk.sv
module simm_bank_cfg_chk
    import mcfg_pkg::*;
#(
    parameter int NS = N_SOCK
) (
    input logic              clk,
    input logic              rst,
    input logic [REQ_W-1:0]  cfg_req_mb,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_rdata,
    input logic [NS-1:0]     dec_sel,
    input logic              dec_miss
);
    logic mapped;
    assign mapped = (io_addr == A_BIGID) || (io_addr == A_PRES) ||
                    (io_addr == A_SIZE)  || (io_addr == A_PARITY);

    assert_bigid_upper_R1: assert property (@(posedge clk) disable iff (rst)
        io_rd && io_addr == A_BIGID |-> io_rdata[7:6] == 2'b00);

    assert_bigid_small_req_R3: assert property (@(posedge clk) disable iff (rst)
        io_rd && io_addr == A_BIGID && cfg_req_mb < REQ_W'(BIG_PAIR_MB)
        |-> io_rdata == '0);

    assert_pres_upper_R2: assert property (@(posedge clk) disable iff (rst)
        io_rd && io_addr == A_PRES |-> io_rdata[7:6] == 2'b11);

    assert_size_upper_R4: assert property (@(posedge clk) disable iff (rst)
        io_rd && io_addr == A_SIZE |-> io_rdata[7:5] == 3'b000);

    assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
        io_rd && io_addr == A_PARITY |-> io_rdata == PARITY_OK);

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> io_rdata == '0);

    assert_size_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && io_rd && io_addr == A_SIZE |-> io_rdata == '0);

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_sel));

    assert_miss_consistent_R11: assert property (@(posedge clk) disable iff (rst)
        dec_miss == (dec_sel == '0));
endmodule

bind simm_bank_cfg simm_bank_cfg_chk #(.NS(NS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_req_mb (cfg_req_mb),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .dec_sel    (dec_sel),
    .dec_miss   (dec_miss)
);

// File: tb/simm_bank_cfg_tb.sv
module simm_bank_cfg_tb;
    import mcfg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [REQ_W-1:0]  cfg_req_mb = 8'd96;
    logic              cfg_auto = 1'b1;
    logic [IO_AW-1:0]  io_addr = '0;
    logic              io_rd = 1'b0;
    logic              io_wr = 1'b0;
    logic [DATA_W-1:0] io_wdata = '0;
    logic [DATA_W-1:0] io_rdata;
    logic [END_W-1:0]  dec_page = '0;
    logic [5:0]        dec_sel;
    logic              dec_miss;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    simm_bank_cfg u_dut (
        .clk(clk), .rst(rst), .cfg_req_mb(cfg_req_mb), .cfg_auto(cfg_auto),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .dec_page(dec_page), .dec_sel(dec_sel),
        .dec_miss(dec_miss)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
    } vec_t;

    // config: 96 MB, auto on -> sizes 32,32,8,8,8,8
    localparam vec_t VECS [14] = '{
        '{1'b0, 12'h803, 8'h00, 8'h03},  // R1 big modules in sockets 0,1
        '{1'b0, 12'h804, 8'h00, 8'hC0},  // R2 all six present
        '{1'b0, 12'h841, 8'h00, 8'h01},  // R8
        '{1'b0, 12'h800, 8'h00, 8'h00},  // R9 unmapped read
        '{1'b0, 12'h820, 8'h00, 8'h00},  // R10 ends cleared
        '{1'b1, 12'h820, 8'h45, 8'h00},  // R6 slot2 <- 5
        '{1'b1, 12'h820, 8'h23, 8'h00},  // R6 slot1 <- 3
        '{1'b0, 12'h804, 8'h00, 8'hC0},  // R5 rewind
        '{1'b0, 12'h820, 8'h00, 8'h00},  // R4 slot0
        '{1'b0, 12'h820, 8'h00, 8'h03},  // R4 slot1
        '{1'b0, 12'h820, 8'h00, 8'h05},  // R4 slot2
        '{1'b0, 12'h820, 8'h00, 8'h00},  // R4 slot3
        '{1'b1, 12'h830, 8'hFF, 8'h00},  // R9 unmapped write
        '{1'b0, 12'h830, 8'h00, 8'h00}   // R9 still reads 0
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] mb, input logic au);
        @(negedge clk);
        cfg_req_mb = mb; cfg_auto = au; rst = 1'b1;
        io_rd = 1'b0; io_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic io_op(input logic wr, input logic [11:0] a, input logic [7:0] d,
                         input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
        #1;
        if (!wr) check8(req, io_rdata, exp);
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic dec_chk(input logic [4:0] pg, input logic [5:0] exp_sel,
                           input string req);
        @(negedge clk);
        dec_page = pg;
        #1;
        check8(req, {2'b00, dec_sel}, {2'b00, exp_sel});
        check8(req, {7'd0, dec_miss}, {7'd0, exp_sel == 6'd0});
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(8'd96, 1'b1);
        // R10 auto placement: pages 0-3,4-7,8,9,10,11; R11 decode
        dec_chk(5'd0,  6'b000001, "R10/R11");
        dec_chk(5'd5,  6'b000010, "R10/R11");
        dec_chk(5'd9,  6'b001000, "R10/R11");
        dec_chk(5'd11, 6'b100000, "R10/R11");
        dec_chk(5'd12, 6'b000000, "R11 miss");

        for (int i = 0; i < 14; i++)
            io_op(VECS[i].is_wr, VECS[i].addr, VECS[i].data, VECS[i].exp, "R1/R2/R4/R5/R6/R8/R9/R10");

        // R7: sockets 0 and 1 both now based at 0, lowest wins (R11)
        dec_chk(5'd2, 6'b000001, "R7 priority");
        dec_chk(5'd5, 6'b000000, "R7 socket1 moved");
        // R7: end equal start -> socket0 disabled
        io_op(1'b1, A_SIZE, 8'h20, 8'h00, "R7");
        dec_chk(5'd2, 6'b000010, "R7 disable");
        // slots 0 and 7 touch no socket; R6 stores them
        io_op(1'b1, A_SIZE, 8'h07, 8'h00, "R6");
        io_op(1'b1, A_SIZE, 8'hE9, 8'h00, "R6");
        dec_chk(5'd2, 6'b000010, "R7 slot0/7 no effect");
        dec_chk(5'd8, 6'b000100, "R7 slot0/7 no effect");
        // full walk with wrap (R4), after rewind (R5)
        io_op(1'b0, A_PRES, 8'h00, 8'hC0, "R5");
        io_op(1'b0, A_SIZE, 8'h00, 8'h07, "R4 slot0");
        io_op(1'b0, A_SIZE, 8'h00, 8'h00, "R4 slot1");
        io_op(1'b0, A_SIZE, 8'h00, 8'h05, "R4 slot2");
        io_op(1'b0, A_SIZE, 8'h00, 8'h00, "R4 slot3");
        io_op(1'b0, A_PRES, 8'h00, 8'hC0, "R5 mid-walk");
        io_op(1'b0, A_SIZE, 8'h00, 8'h07, "R5 back at slot0");
        for (int i = 1; i < 7; i++)
            io_op(1'b0, A_SIZE, 8'h00, (i == 2) ? 8'h05 : 8'h00, "R4 walk");
        io_op(1'b0, A_SIZE, 8'h00, 8'h09, "R4 slot7");
        io_op(1'b0, A_SIZE, 8'h00, 8'h07, "R4 wrap");
        // R7 chaining: slot3 end 10, start = slot2 end 5
        io_op(1'b1, A_SIZE, 8'h6A, 8'h00, "R7");
        dec_chk(5'd5, 6'b000100, "R7 chained base");
        io_op(1'b1, A_SIZE, 8'h65, 8'h00, "R7");
        dec_chk(5'd5, 6'b000000, "R7 end equals start");

        // R3 allocation corners
        do_reset(8'd200, 1'b1);
        io_op(1'b0, A_BIGID, 8'h00, 8'h3F, "R3/R1 200MB");
        io_op(1'b0, A_PRES,  8'h00, 8'hC0, "R3/R2 200MB");
        dec_chk(5'd20, 6'b100000, "R3/R10");
        dec_chk(5'd24, 6'b000000, "R3/R11");

        do_reset(8'd130, 1'b1);
        io_op(1'b0, A_BIGID, 8'h00, 8'h0F, "R3 130MB");
        io_op(1'b0, A_PRES,  8'h00, 8'hF0, "R3 130MB");

        do_reset(8'd40, 1'b1);
        io_op(1'b0, A_BIGID, 8'h00, 8'h00, "R3 40MB");
        io_op(1'b0, A_PRES,  8'h00, 8'hF0, "R3 40MB");
        dec_chk(5'd3, 6'b001000, "R3/R10");

        do_reset(8'd16, 1'b1);
        io_op(1'b0, A_PRES, 8'h00, 8'hFC, "R3 16MB");
        dec_chk(5'd1, 6'b000010, "R10");
        dec_chk(5'd2, 6'b000000, "R11");
        // R7: write to slot for unpopulated socket leaves decode unchanged
        io_op(1'b1, A_SIZE, 8'h86, 8'h00, "R7");
        dec_chk(5'd2, 6'b000000, "R7 unpopulated");

        do_reset(8'd0, 1'b1);
        io_op(1'b0, A_PRES, 8'h00, 8'hFF, "R3/R2 empty");
        dec_chk(5'd0, 6'b000000, "R11");

        do_reset(8'd96, 1'b0);
        dec_chk(5'd0, 6'b000000, "R10 auto off");
        io_op(1'b0, A_PARITY, 8'h00, 8'h01, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule